// File: doc/BRIEF.md
# CPU clock select and oscillator control

This block produces the CPU clock of a small microcontroller core as a one-cycle tick. The tick is derived from one of two sources: a high-speed system clock or an internal ring oscillator. Each source reaches the block as an edge strobe that is sampled in the block's own clock domain. The selected source is divided by a power of two before each tick is emitted. Downstream sequencing logic counts the ticks in pairs, since the shortest instruction takes two CPU clocks.

Software chooses a source and a divider through a configuration write. A write that asks for a setting the ring oscillator cannot run at is dropped. An accepted setting waits in a pending slot and is committed only when the current divided period ends, so every tick interval is a whole period of either the old or the new setting.

A separate 8-bit mode register holds the ring oscillator's stop bit. The bit can be written as a byte or changed by a single-bit set or clear access. The stop bit turns the oscillator enable off only when a board strap permits stopping and the CPU is running from the high-speed clock. The oscillator that is driving the CPU, or about to drive it, is never turned off.

Top module: `cpu_clk_ctrl`

## Requirements
- R1: During and after reset, `reg_rdata_o` reads 00h, `ro_en_o` is 1 and `cpu_tick_o` is 0 while reset is held. After reset the source is the high-speed clock at divide-by-1, so one tick follows each high-speed strobe.
- R2: A configuration write with `cfg_src_i` = 0 (high-speed) and `cfg_div_i` codes 0, 1, 2, 3 or 4 sets 1, 2, 4, 8 or 16 high-speed strobes per tick. Each tick is one `clk_i` cycle wide.
- R3: A configuration write with `cfg_src_i` = 1 (ring oscillator) and `cfg_div_i` codes 0 or 1 sets 1 or 2 ring-oscillator strobes per tick.
- R4: A configuration write is ignored, and the previous setting is kept, in two cases: `cfg_src_i` = 1 with a `cfg_div_i` code of 2 to 4, or any write with a code of 5 to 7.
- R5: A new setting takes effect only at the tick that ends the current period. The interval that contains the write keeps its old length.
- R6: A byte write (`reg_we_i`) loads the stop bit from `reg_wdata_i[0]` and ignores the other data bits. `reg_rdata_o` always reads {7'b0, stop bit}.
- R7: `bit_set_i` sets the stop bit and `bit_clr_i` clears it. In the same cycle a byte write takes priority over both, and set takes priority over clear.
- R8: `ro_en_o` is 0 only while `stop_allow_i` = 1, the stop bit = 1, and both the running source and the requested source are the high-speed clock. Otherwise it is 1. It follows its inputs one cycle later.
- R9: A requested switch to the ring oscillator forces `ro_en_o` to 1 before the switch. The switch commits only at a period boundary where `ro_en_o` is already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; source strobes are sampled on its rising edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| hs_pulse_i | input | 1 | One-cycle strobe per high-speed source edge |
| ro_pulse_i | input | 1 | One-cycle strobe per ring-oscillator edge |
| stop_allow_i | input | 1 | Strap: 1 permits stopping the ring oscillator |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_src_i | input | 1 | Requested source: 0 high-speed, 1 ring oscillator |
| cfg_div_i | input | 3 | Requested divider code (divide by 2^code) |
| reg_we_i | input | 1 | Byte write strobe for the mode register |
| reg_wdata_i | input | 8 | Byte write data |
| bit_set_i | input | 1 | Single-bit set of the stop bit |
| bit_clr_i | input | 1 | Single-bit clear of the stop bit |
| reg_rdata_o | output | 8 | Mode register read data |
| cpu_tick_o | output | 1 | One-cycle CPU clock tick |
| ro_en_o | output | 1 | Ring oscillator enable |

## Verification
The bench measures the tick interval for all seven legal source and divider pairs. A design that mixed up divider codes, or let the ring oscillator run at divide-by-4, would show the wrong interval. It writes /1 just after a /16 tick and expects a full 32-cycle interval before the first short one. A design that committed at once would emit a clipped period. It walks the strap, stop bit and source through every combination, and then switches to the ring oscillator while the oscillator is stopped. A design that gated only on the requested source, or that committed before re-enabling the oscillator, would lose the CPU clock for good. Byte-over-bit priority and masking of the upper data bits are probed through the read data.

// File: rtl/cpu_clk_ctrl_pkg.sv
// Shared types for the CPU clock control unit.
// Assumes: the divider code width is fixed here for all users.
package cpu_clk_ctrl_pkg;
    localparam int CFG_DIV_W = 3;

    typedef enum logic {
        SRC_HS = 1'b0,
        SRC_RO = 1'b1
    } clk_src_e;

    typedef struct packed {
        clk_src_e               src;
        logic [CFG_DIV_W-1:0]   div;
    } clk_cfg_t;
endpackage

// File: rtl/cpu_clk_cfg.sv
// Pending clock configuration slot.
// Holds the last accepted source/divider request and drops any request that
// the chosen source cannot run at.
// Assumes: divider code n means divide by 2^n.
module cpu_clk_cfg
    import cpu_clk_ctrl_pkg::*;
#(
    parameter int HS_MAX_LOG2 = 4,
    parameter int RO_MAX_LOG2 = 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 cfg_we_i,
    input  logic                 cfg_src_i,
    input  logic [CFG_DIV_W-1:0] cfg_div_i,
    output clk_cfg_t             pend_o
);
    localparam logic [CFG_DIV_W-1:0] HS_LIM = CFG_DIV_W'(HS_MAX_LOG2);
    localparam logic [CFG_DIV_W-1:0] RO_LIM = CFG_DIV_W'(RO_MAX_LOG2);

    clk_cfg_t pend_q;
    logic     hs_ok;
    logic     ro_ok;
    logic     req_ro;
    logic     accept;

    // Legality of the incoming request for its own source.
    always_comb begin
        req_ro = (clk_src_e'(cfg_src_i) == SRC_RO);
        hs_ok  = (cfg_div_i <= HS_LIM);
        ro_ok  = (cfg_div_i <= RO_LIM);
        accept = cfg_we_i && hs_ok && (!req_ro || ro_ok);
    end

    // Capture accepted requests into the pending slot.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_q <= '{src: SRC_HS, div: '0};
        end else if (accept) begin
            pend_q <= '{src: clk_src_e'(cfg_src_i), div: cfg_div_i};
        end
    end

    assign pend_o = pend_q;

    // R4
    ro_div_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_src_i && (cfg_div_i > RO_LIM)) |=> $stable(pend_q));

    // R4
    code_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && (cfg_div_i > HS_LIM)) |=> $stable(pend_q));
endmodule

// File: rtl/cpu_clk_div.sv
// Tick generator: counts strobes of the running source and emits one tick per
// divided period. The pending setting is committed only at the tick that
// closes a period. A switch to the ring oscillator also waits until the
// oscillator enable is already on.
// Assumes: the strobes are one cycle wide and synchronous to clk_i.
module cpu_clk_div
    import cpu_clk_ctrl_pkg::*;
#(
    parameter int HS_MAX_LOG2 = 4,
    parameter int RO_MAX_LOG2 = 1
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     hs_pulse_i,
    input  logic     ro_pulse_i,
    input  logic     ro_ready_i,
    input  clk_cfg_t pend_i,
    output logic     tick_o,
    output logic     act_ro_o
);
    localparam int              CNT_W  = (HS_MAX_LOG2 < 1) ? 1 : HS_MAX_LOG2;
    localparam logic [CNT_W:0]  ONE    = (CNT_W+1)'(1);
    localparam logic [CFG_DIV_W-1:0] RO_LIM = CFG_DIV_W'(RO_MAX_LOG2);

    clk_cfg_t         act_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick_q;
    logic             src_pulse;
    logic [CNT_W:0]   last_cnt;
    logic             period_end;
    logic             swap_ok;

    // Strobe of the running source and end-of-period detection.
    always_comb begin
        src_pulse  = (act_q.src == SRC_RO) ? ro_pulse_i : hs_pulse_i;
        last_cnt   = (ONE << act_q.div) - ONE;
        period_end = src_pulse && ({1'b0, cnt_q} == last_cnt);
        swap_ok    = !((pend_i.src == SRC_RO) && !ro_ready_i);
    end

    // Period counter, tick register and boundary commit of the setting.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            act_q  <= '{src: SRC_HS, div: '0};
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= period_end;
            if (period_end) begin
                cnt_q <= '0;
            end else if (src_pulse) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (period_end && swap_ok) begin
                act_q <= pend_i;
            end
        end
    end

    assign tick_o   = tick_q;
    assign act_ro_o = (act_q.src == SRC_RO);

    // R5
    commit_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(act_q) |-> tick_q);

    // R9
    ro_switch_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(act_q.src) |-> $past(ro_ready_i));

    // R3
    ro_div_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_q.src == SRC_RO) |-> (act_q.div <= RO_LIM));

    // R2
    tick_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_q && !src_pulse) |=> !tick_q);
endmodule

// File: rtl/cpu_clk_osc.sv
// Ring-oscillator mode register and enable gate.
// The register is REG_W bits wide, with the stop bit at STOP_BIT and all
// other bits reading zero. The enable drops only when the strap permits it
// and neither the running nor the requested source is the ring oscillator.
// Assumes: byte write beats set, and set beats clear, in the same cycle.
module cpu_clk_osc #(
    parameter int REG_W    = 8,
    parameter int STOP_BIT = 0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             reg_we_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    input  logic             bit_set_i,
    input  logic             bit_clr_i,
    input  logic             stop_allow_i,
    input  logic             act_ro_i,
    input  logic             pend_ro_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             ro_en_o
);
    localparam logic [REG_W-1:0] STOP_MASK = REG_W'(1) << STOP_BIT;

    logic stop_q;
    logic ro_en_q;
    logic wr_bit;
    logic may_stop;

    // Stop bit value carried by a byte write, and the stop-permission condition.
    always_comb begin
        wr_bit   = |(reg_wdata_i & STOP_MASK);
        may_stop = stop_allow_i && !act_ro_i && !pend_ro_i;
    end

    // Stop bit storage with byte, set and clear accesses.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            stop_q <= 1'b0;
        end else if (reg_we_i) begin
            stop_q <= wr_bit;
        end else if (bit_set_i) begin
            stop_q <= 1'b1;
        end else if (bit_clr_i) begin
            stop_q <= 1'b0;
        end
    end

    // Registered oscillator enable.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ro_en_q <= 1'b1;
        end else begin
            ro_en_q <= !(may_stop && stop_q);
        end
    end

    // Read data: stop bit in place, every other bit zero.
    for (genvar i = 0; i < REG_W; i++) begin : g_rd
        if (i == STOP_BIT) begin : g_stop
            assign reg_rdata_o[i] = stop_q;
        end else begin : g_zero
            assign reg_rdata_o[i] = 1'b0;
        end
    end

    assign ro_en_o = ro_en_q;

    // R7
    bit_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_set_i && !reg_we_i) |=> reg_rdata_o[STOP_BIT]);

    // R7
    bit_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_clr_i && !bit_set_i && !reg_we_i) |=> !reg_rdata_o[STOP_BIT]);

    // R8
    strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stop_allow_i |=> ro_en_o);

    // R9
    ro_in_use_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_ro_i || pend_ro_i) |=> ro_en_o);
endmodule

// File: rtl/cpu_clk_ctrl.sv
// CPU clock control unit top level.
// Joins the pending configuration slot, the tick generator and the ring
// oscillator mode register. All inputs are synchronous to clk_i.
// Assumes: source edges arrive as one-cycle strobes.
module cpu_clk_ctrl
    import cpu_clk_ctrl_pkg::*;
#(
    parameter int HS_MAX_LOG2 = 4,
    parameter int RO_MAX_LOG2 = 1,
    parameter int REG_W       = 8,
    parameter int STOP_BIT    = 0
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 hs_pulse_i,
    input  logic                 ro_pulse_i,
    input  logic                 stop_allow_i,
    input  logic                 cfg_we_i,
    input  logic                 cfg_src_i,
    input  logic [CFG_DIV_W-1:0] cfg_div_i,
    input  logic                 reg_we_i,
    input  logic [REG_W-1:0]     reg_wdata_i,
    input  logic                 bit_set_i,
    input  logic                 bit_clr_i,
    output logic [REG_W-1:0]     reg_rdata_o,
    output logic                 cpu_tick_o,
    output logic                 ro_en_o
);
    clk_cfg_t pend;
    logic     act_ro;
    logic     pend_ro;
    logic     ro_en;

    assign pend_ro = (pend.src == SRC_RO);

    cpu_clk_cfg #(
        .HS_MAX_LOG2(HS_MAX_LOG2),
        .RO_MAX_LOG2(RO_MAX_LOG2)
    ) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cfg_we_i  (cfg_we_i),
        .cfg_src_i (cfg_src_i),
        .cfg_div_i (cfg_div_i),
        .pend_o    (pend)
    );

    cpu_clk_div #(
        .HS_MAX_LOG2(HS_MAX_LOG2),
        .RO_MAX_LOG2(RO_MAX_LOG2)
    ) u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .hs_pulse_i (hs_pulse_i),
        .ro_pulse_i (ro_pulse_i),
        .ro_ready_i (ro_en),
        .pend_i     (pend),
        .tick_o     (cpu_tick_o),
        .act_ro_o   (act_ro)
    );

    cpu_clk_osc #(
        .REG_W   (REG_W),
        .STOP_BIT(STOP_BIT)
    ) u_osc (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .reg_we_i     (reg_we_i),
        .reg_wdata_i  (reg_wdata_i),
        .bit_set_i    (bit_set_i),
        .bit_clr_i    (bit_clr_i),
        .stop_allow_i (stop_allow_i),
        .act_ro_i     (act_ro),
        .pend_ro_i    (pend_ro),
        .reg_rdata_o  (reg_rdata_o),
        .ro_en_o      (ro_en)
    );

    assign ro_en_o = ro_en;

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!cpu_tick_o && ro_en_o && (reg_rdata_o == '0)));
endmodule

// File: tb/cpu_clk_ctrl_bench.sv
`timescale 1ns/1ps
module cpu_clk_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs_p = 1'b0;
    logic       ro_p = 1'b0;
    logic       allow = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_src = 1'b0;
    logic [2:0] cfg_div = 3'd0;
    logic       reg_we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       bset = 1'b0;
    logic       bclr = 1'b0;
    logic [7:0] rdata;
    logic       tick;
    logic       ro_en;

    localparam int HS_PER = 2;
    localparam int RO_PER = 3;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    resync = 1'b0;
    int    last = 0;
    int    t0;

    cpu_clk_ctrl u_cpu_clk_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .hs_pulse_i(hs_p), .ro_pulse_i(ro_p),
        .stop_allow_i(allow), .cfg_we_i(cfg_we), .cfg_src_i(cfg_src),
        .cfg_div_i(cfg_div), .reg_we_i(reg_we), .reg_wdata_i(wdata),
        .bit_set_i(bset), .bit_clr_i(bclr), .reg_rdata_o(rdata),
        .cpu_tick_o(tick), .ro_en_o(ro_en)
    );

    initial forever #2.5 clk = ~clk;
    initial forever begin @(posedge clk); cyc++; end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Source strobe models: high-speed free-running, ring only while enabled.
    initial begin
        int h = 0;
        int r = 0;
        forever begin
            @(negedge clk);
            h++;
            hs_p = (h % HS_PER == 0);
            if (ro_en) begin
                r++;
                ro_p = (r % RO_PER == 0);
            end else begin
                ro_p = 1'b0;
            end
        end
    end

    // Monitor: measures tick intervals and pops expected items.
    initial forever begin
        @(negedge clk);
        if (tick) begin
            if (resync) resync = 1'b0;
            else if (exp_q.size() > 0) check(tag_q.pop_front(), cyc - last, exp_q.pop_front());
            last = cyc;
        end
    end

    task automatic wait_ticks(int n);
        repeat (n) begin
            @(negedge clk);
            while (!tick) @(negedge clk);
        end
    endtask

    // Driver: settle, then push expected tick intervals for the scoreboard.
    task automatic expect_period(int len, int per, string tag);
        wait_ticks(3);
        @(posedge clk);
        resync = 1'b1;
        repeat (3) begin
            exp_q.push_back(len * per);
            tag_q.push_back(tag);
        end
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic do_cfg(logic src, logic [2:0] div);
        @(negedge clk);
        cfg_we = 1'b1; cfg_src = src; cfg_div = div;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reg(logic we, logic [7:0] wd, logic s, logic c);
        @(negedge clk);
        reg_we = we; wdata = wd; bset = s; bclr = c;
        @(negedge clk);
        reg_we = 1'b0; bset = 1'b0; bclr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got %0d expected 0 remaining cycles", 0);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rdata", int'(rdata), 0);
        check("R1 reset ro_en", int'(ro_en), 1);
        check("R1 reset tick", int'(tick), 0);
        @(negedge clk);
        rst_n = 1'b1;
        expect_period(1, HS_PER, "R1 default HS/1");

        for (int d = 0; d < 5; d++) begin
            do_cfg(1'b0, 3'(d));
            expect_period(1 << d, HS_PER, $sformatf("R2 HS div code %0d", d));
        end

        // Boundary commit: /16 running, request /1 right after a tick.
        wait_ticks(1);
        t0 = cyc;
        do_cfg(1'b0, 3'd0);
        wait_ticks(1);
        check("R5 old period kept", cyc - t0, 16 * HS_PER);
        t0 = cyc;
        wait_ticks(1);
        check("R5 new period after boundary", cyc - t0, HS_PER);

        do_cfg(1'b1, 3'd0);
        expect_period(1, RO_PER, "R3 RO div code 0");
        do_cfg(1'b1, 3'd1);
        expect_period(2, RO_PER, "R3 RO div code 1");

        do_cfg(1'b1, 3'd2);
        expect_period(2, RO_PER, "R4 RO code 2 ignored");
        do_cfg(1'b1, 3'd4);
        expect_period(2, RO_PER, "R4 RO code 4 ignored");
        do_cfg(1'b0, 3'd5);
        expect_period(2, RO_PER, "R4 code 5 ignored");
        do_cfg(1'b0, 3'd3);
        expect_period(8, HS_PER, "R2 HS code 3 from RO");
        do_cfg(1'b0, 3'd7);
        expect_period(8, HS_PER, "R4 code 7 ignored");
        do_cfg(1'b1, 3'd3);
        expect_period(8, HS_PER, "R4 RO code 3 ignored");

        do_reg(1'b1, 8'hFF, 1'b0, 1'b0);
        check("R6 byte FF reads 01", int'(rdata), 8'h01);
        do_reg(1'b1, 8'hFE, 1'b0, 1'b0);
        check("R6 byte FE reads 00", int'(rdata), 8'h00);
        do_reg(1'b0, 8'h00, 1'b1, 1'b0);
        check("R7 bit set", int'(rdata), 8'h01);
        do_reg(1'b0, 8'hFF, 1'b0, 1'b1);
        check("R7 bit clear", int'(rdata), 8'h00);
        do_reg(1'b0, 8'h00, 1'b1, 1'b0);
        do_reg(1'b1, 8'h00, 1'b1, 1'b0);
        check("R7 byte beats set", int'(rdata), 8'h00);
        do_reg(1'b1, 8'h01, 1'b0, 1'b1);
        check("R7 byte beats clear", int'(rdata), 8'h01);
        do_reg(1'b0, 8'h00, 1'b1, 1'b1);
        check("R7 set beats clear", int'(rdata), 8'h01);

        do_cfg(1'b0, 3'd0);
        wait_ticks(3);
        for (int a = 0; a < 2; a++) begin
            for (int s = 0; s < 2; s++) begin
                allow = a[0];
                do_reg(1'b1, s[0] ? 8'h81 : 8'h7E, 1'b0, 1'b0);
                @(negedge clk);
                check($sformatf("R8 HS strap %0d stop %0d", a, s), int'(ro_en), (a == 1 && s == 1) ? 0 : 1);
            end
        end

        do_cfg(1'b1, 3'd0);
        @(negedge clk);
        check("R9 enable forced before switch", int'(ro_en), 1);
        expect_period(1, RO_PER, "R9 switch to RO completes");

        for (int a = 0; a < 2; a++) begin
            for (int s = 0; s < 2; s++) begin
                allow = a[0];
                do_reg(1'b1, s[0] ? 8'h01 : 8'h00, 1'b0, 1'b0);
                @(negedge clk);
                check($sformatf("R8 RO strap %0d stop %0d", a, s), int'(ro_en), 1);
            end
        end

        do_cfg(1'b0, 3'd0);
        wait_ticks(3);
        @(negedge clk);
        check("R8 back on HS stops oscillator", int'(ro_en), 0);
        check("R6 stop bit still set", int'(rdata), 8'h01);
        expect_period(1, HS_PER, "R8 HS runs with oscillator off");

        report();
        $finish;
    end
endmodule